// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This block erases one sector of a serial NOR flash device with no processor involvement. A single start pulse hands it a bank number, a sector index and the device geometry (total size and sector count, both as powers of two). From then on it drives a command transfer engine one frame at a time. It first reads the device status until no write is in progress. It then sends write-enable and reads status until the write-enable latch for the chosen bank is set. Next it sends the sector-erase frame with a 24-bit byte address, and reads status again until the erase completes.

Every status retry waits for the next pulse of a free-running millisecond tick. Each of the three polling phases has its own retry limit. When the operation ends, the block raises a one-cycle done pulse with a two-bit result code: success, busy timeout, or write-enable failure. At the start of each operation it also pulses a strobe that clears the transfer engine's sticky error flags.

Top module: `sec_erase_seq`

## Requirements
- R1: After reset, busy, done, cmdReq and errClr are low and errCode is 00.
- R2: A start accepted while idle produces exactly one errClr pulse, and that pulse comes before the first cmdReq of the operation.
- R3: Each status read is a frame with opcode 0x05, txLen 1 and rxLen 1. Bit 0 of the returned byte is the write-in-progress flag. Before any write-enable, status is read until that bit is 0. A repeated status read is issued only after a msTick pulse has arrived since the previous read completed.
- R4: In the pre-erase phase at most preLimit status reads are made (at least one). If the last allowed read still shows write-in-progress, the operation ends with errCode 01, and no write-enable or erase frame is sent.
- R5: Write-enable is a frame with opcode 0x06, txLen 1 and rxLen 0. The status reads that follow test bit (WEL_SHIFT + bank) of the returned byte, with WEL_SHIFT = 4. If that bit is not seen set within welLimit reads, the operation ends with errCode 10 and no erase frame is sent. A latch bit set for a different bank does not count.
- R6: The erase frame has opcode 0xD8, txLen 4 and rxLen 0. Its address is sectorIdx × 2^(sizeLog2 − countLog2), truncated to 24 bits.
- R7: After the erase frame, status is read until write-in-progress is 0, up to eraseLimit reads. On success errCode is 00; if the limit is exhausted, errCode is 01.
- R8: A start pulse while busy is ignored. It does not restart the operation, and it does not change the bank, address or number of frames.
- R9: done is a one-cycle pulse, exactly one per operation. errCode is nonzero only in the done cycle. busy is high from the cycle after start until done.
- R10: Every frame of an operation carries the bank number latched at start on cmdBank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| bankSel | input | BANK_W | Bank to erase in |
| sectorIdx | input | SEC_W | Sector index |
| sizeLog2 | input | 5 | log2 of device size in bytes |
| countLog2 | input | 5 | log2 of sector count |
| preLimit | input | CNT_W | Status read limit before write-enable |
| welLimit | input | CNT_W | Status read limit for the write-enable latch |
| eraseLimit | input | CNT_W | Status read limit after the erase frame |
| msTick | input | 1 | One-cycle pulse every millisecond |
| cmdReq | output | 1 | One-cycle frame request to the transfer engine |
| cmdOpcode | output | 8 | Frame opcode |
| cmdAddr | output | 24 | Frame address bytes |
| cmdTxLen | output | 3 | Bytes sent, including opcode |
| cmdRxLen | output | 2 | Bytes received |
| cmdBank | output | BANK_W | Bank select for the frame |
| cmdDone | input | 1 | Frame complete pulse from the engine |
| cmdRxData | input | 8 | Received status byte, valid with cmdDone |
| errClr | output | 1 | Pulse clearing the engine's error flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |
| errCode | output | 2 | 00 ok, 01 busy timeout, 10 write-enable failure |

## Verification
The bench keeps the default widths: four banks, 12-bit sector index and 8-bit retry counters. These widths let the status-bit index cover latch bits 4 through 7, and they reach both the largest geometry (64 sectors of 256 KB, top sector at 0xFC0000) and a smaller 1 MB device. The retry limits are set per scenario at 2 to 10, so every timeout exit fires within a few hundred cycles. The millisecond tick is a pulse every eight cycles, so retry spacing can be observed directly.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
  typedef enum logic [1:0] {CMD_NONE, CMD_RDSR, CMD_WREN, CMD_ERASE} cmdKindT;
  typedef enum logic [1:0] {PH_PRE, PH_WEL, PH_POST} pollPhaseT;

  localparam logic [1:0] ERR_OK   = 2'b00;
  localparam logic [1:0] ERR_BUSY = 2'b01;
  localparam logic [1:0] ERR_WEL  = 2'b10;

  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'hD8;

  typedef struct packed {
    logic      latchReq;
    cmdKindT   cmdKind;
    logic      cmdFire;
    pollPhaseT phase;
    logic      cntClr;
    logic      cntInc;
    logic      errSet;
    logic [1:0] errVal;
  } ctrlStrobeT;
endpackage

// File: rtl/sec_erase_ctrl.sv
module sec_erase_ctrl
  import sec_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       msTick,
  input  logic       cmdDone,
  input  logic       wipNow,
  input  logic       welNow,
  input  logic       limitHit,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       done,
  output logic       errClr
);
  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_POLL_ISSUE, S_POLL_WAIT, S_POLL_TICK,
    S_WEN_ISSUE, S_WEN_WAIT, S_ERS_ISSUE, S_ERS_WAIT, S_FIN
  } stateT;

  stateT     stateQ, stateN;
  pollPhaseT phaseQ, phaseN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      phaseQ <= PH_PRE;
    end else begin
      stateQ <= stateN;
      phaseQ <= phaseN;
    end
  end

  always_comb begin
    stateN          = stateQ;
    phaseN          = phaseQ;
    strobe          = '0;
    strobe.cmdKind  = CMD_NONE;
    strobe.phase    = phaseQ;
    strobe.errVal   = ERR_OK;
    errClr          = 1'b0;
    done            = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strobe.latchReq = 1'b1;
          stateN          = S_CLR;
        end
      end
      S_CLR: begin
        errClr        = 1'b1;
        phaseN        = PH_PRE;
        strobe.cntClr = 1'b1;
        stateN        = S_POLL_ISSUE;
      end
      S_POLL_ISSUE: begin
        strobe.cmdKind = CMD_RDSR;
        strobe.cmdFire = 1'b1;
        stateN         = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        strobe.cmdKind = CMD_RDSR;
        if (cmdDone) begin
          if (phaseQ == PH_WEL) begin
            if (welNow) begin
              stateN = S_ERS_ISSUE;
            end else if (limitHit) begin
              strobe.errSet = 1'b1;
              strobe.errVal = ERR_WEL;
              stateN        = S_FIN;
            end else begin
              strobe.cntInc = 1'b1;
              stateN        = S_POLL_TICK;
            end
          end else begin
            if (!wipNow) begin
              stateN = (phaseQ == PH_PRE) ? S_WEN_ISSUE : S_FIN;
            end else if (limitHit) begin
              strobe.errSet = 1'b1;
              strobe.errVal = ERR_BUSY;
              stateN        = S_FIN;
            end else begin
              strobe.cntInc = 1'b1;
              stateN        = S_POLL_TICK;
            end
          end
        end
      end
      S_POLL_TICK: begin
        if (msTick) stateN = S_POLL_ISSUE;
      end
      S_WEN_ISSUE: begin
        strobe.cmdKind = CMD_WREN;
        strobe.cmdFire = 1'b1;
        stateN         = S_WEN_WAIT;
      end
      S_WEN_WAIT: begin
        strobe.cmdKind = CMD_WREN;
        if (cmdDone) begin
          phaseN        = PH_WEL;
          strobe.cntClr = 1'b1;
          stateN        = S_POLL_ISSUE;
        end
      end
      S_ERS_ISSUE: begin
        strobe.cmdKind = CMD_ERASE;
        strobe.cmdFire = 1'b1;
        stateN         = S_ERS_WAIT;
      end
      S_ERS_WAIT: begin
        strobe.cmdKind = CMD_ERASE;
        if (cmdDone) begin
          phaseN        = PH_POST;
          strobe.cntClr = 1'b1;
          stateN        = S_POLL_ISSUE;
        end
      end
      S_FIN: begin
        done   = 1'b1;
        stateN = S_IDLE;
      end
      default: stateN = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);

  // R3: a pending retry holds until the tick arrives
  a_r3_wait_for_tick: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_POLL_TICK && !msTick) |=> (stateQ == S_POLL_TICK));

  // R8: start while busy never restarts the sequence
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE && start) |=> (stateQ != S_CLR));

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: the clear strobe never coincides with a frame request
  a_r2_clr_alone: assert property (@(posedge clk) disable iff (!rstN)
    errClr |-> !strobe.cmdFire);
endmodule

// File: rtl/sec_erase_dp.sv
module sec_erase_dp
  import sec_erase_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int SEC_W    = 12,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 24,
  parameter int STAT_W   = 8,
  parameter int WEL_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [SEC_W-1:0]  sectorIdx,
  input  logic [4:0]        sizeLog2,
  input  logic [4:0]        countLog2,
  input  logic [CNT_W-1:0]  preLimit,
  input  logic [CNT_W-1:0]  welLimit,
  input  logic [CNT_W-1:0]  eraseLimit,
  input  logic [STAT_W-1:0] cmdRxData,
  output logic              wipNow,
  output logic              welNow,
  output logic              limitHit,
  output logic              cmdReq,
  output logic [7:0]        cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [2:0]        cmdTxLen,
  output logic [1:0]        cmdRxLen,
  output logic [BANK_W-1:0] cmdBank,
  output logic [1:0]        errQ
);
  localparam int BANKS   = 1 << BANK_W;
  localparam int WIDE_W  = ADDR_W + SEC_W;

  logic [BANK_W-1:0] bankQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  preQ, welQ, eraseQ, cntQ, limSel;
  logic [4:0]        shiftAmt;
  logic [WIDE_W-1:0] wideAddr;
  logic [BANKS-1:0]  welBits;

  assign shiftAmt = sizeLog2 - countLog2;
  assign wideAddr = {{ADDR_W{1'b0}}, sectorIdx} << shiftAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ  <= '0;
      addrQ  <= '0;
      preQ   <= '0;
      welQ   <= '0;
      eraseQ <= '0;
    end else if (strobe.latchReq) begin
      bankQ  <= bankSel;
      addrQ  <= wideAddr[ADDR_W-1:0];
      preQ   <= preLimit;
      welQ   <= welLimit;
      eraseQ <= eraseLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.cntClr)  cntQ <= '0;
    else if (strobe.cntInc)  cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                errQ <= ERR_OK;
    else if (strobe.latchReq) errQ <= ERR_OK;
    else if (strobe.errSet)   errQ <= strobe.errVal;
  end

  always_comb begin
    unique case (strobe.phase)
      PH_WEL:  limSel = welQ;
      PH_POST: limSel = eraseQ;
      default: limSel = preQ;
    endcase
  end

  assign limitHit = ({1'b0, cntQ} + 1'b1) >= {1'b0, limSel};

  genvar gb;
  generate
    for (gb = 0; gb < BANKS; gb++) begin : g_wel
      assign welBits[gb] = cmdRxData[WEL_SHIFT + gb];
    end
  endgenerate

  assign wipNow = cmdRxData[0];
  assign welNow = welBits[bankQ];

  always_comb begin
    cmdOpcode = OP_RDSR;
    cmdTxLen  = 3'd1;
    cmdRxLen  = 2'd1;
    cmdAddr   = '0;
    unique case (strobe.cmdKind)
      CMD_WREN: begin
        cmdOpcode = OP_WREN;
        cmdRxLen  = 2'd0;
      end
      CMD_ERASE: begin
        cmdOpcode = OP_ERASE;
        cmdTxLen  = 3'd4;
        cmdRxLen  = 2'd0;
        cmdAddr   = addrQ;
      end
      default: ;
    endcase
  end

  assign cmdReq  = strobe.cmdFire;
  assign cmdBank = bankQ;

  // R4: the control never schedules a retry once the limit is reached
  a_r4_no_retry_past_limit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntInc |-> !limitHit);

  // R10: bank and address hold for the whole operation
  a_r10_bank_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchReq |=> ($stable(bankQ) && $stable(addrQ)));
endmodule

// File: rtl/sec_erase_seq.sv
module sec_erase_seq
  import sec_erase_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int SEC_W  = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [SEC_W-1:0]  sectorIdx,
  input  logic [4:0]        sizeLog2,
  input  logic [4:0]        countLog2,
  input  logic [CNT_W-1:0]  preLimit,
  input  logic [CNT_W-1:0]  welLimit,
  input  logic [CNT_W-1:0]  eraseLimit,
  input  logic              msTick,
  output logic              cmdReq,
  output logic [7:0]        cmdOpcode,
  output logic [23:0]       cmdAddr,
  output logic [2:0]        cmdTxLen,
  output logic [1:0]        cmdRxLen,
  output logic [BANK_W-1:0] cmdBank,
  input  logic              cmdDone,
  input  logic [7:0]        cmdRxData,
  output logic              errClr,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode
);
  ctrlStrobeT strobe;
  logic       wipNow, welNow, limitHit;
  logic [1:0] errQ;

  sec_erase_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .msTick(msTick),
    .cmdDone(cmdDone), .wipNow(wipNow), .welNow(welNow),
    .limitHit(limitHit), .strobe(strobe), .busy(busy),
    .done(done), .errClr(errClr)
  );

  sec_erase_dp #(
    .BANK_W(BANK_W), .SEC_W(SEC_W), .CNT_W(CNT_W),
    .ADDR_W(24), .STAT_W(8), .WEL_SHIFT(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankSel(bankSel),
    .sectorIdx(sectorIdx), .sizeLog2(sizeLog2), .countLog2(countLog2),
    .preLimit(preLimit), .welLimit(welLimit), .eraseLimit(eraseLimit),
    .cmdRxData(cmdRxData), .wipNow(wipNow), .welNow(welNow),
    .limitHit(limitHit), .cmdReq(cmdReq), .cmdOpcode(cmdOpcode),
    .cmdAddr(cmdAddr), .cmdTxLen(cmdTxLen), .cmdRxLen(cmdRxLen),
    .cmdBank(cmdBank), .errQ(errQ)
  );

  assign errCode = done ? errQ : ERR_OK;

  // R9: a result code appears only with done
  a_r9_code_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != ERR_OK) |-> done);

  // R9: done only ends an operation that was running
  a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
endmodule

// File: tb/sec_erase_seq_tb.sv
module sec_erase_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  bankSel = '0;
  logic [11:0] sectorIdx = '0;
  logic [4:0]  sizeLog2 = 5'd20, countLog2 = 5'd4;
  logic [7:0]  preLimit = 8'd5, welLimit = 8'd3, eraseLimit = 8'd10;
  logic        msTick = 1'b0;
  logic        cmdReq, errClr, busy, done;
  logic [7:0]  cmdOpcode;
  logic [23:0] cmdAddr;
  logic [2:0]  cmdTxLen;
  logic [1:0]  cmdRxLen, cmdBank, errCode;
  logic        cmdDone = 1'b0;
  logic [7:0]  cmdRxData = '0;

  always #2 clk = ~clk;

  sec_erase_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .bankSel(bankSel),
    .sectorIdx(sectorIdx), .sizeLog2(sizeLog2), .countLog2(countLog2),
    .preLimit(preLimit), .welLimit(welLimit), .eraseLimit(eraseLimit),
    .msTick(msTick), .cmdReq(cmdReq), .cmdOpcode(cmdOpcode),
    .cmdAddr(cmdAddr), .cmdTxLen(cmdTxLen), .cmdRxLen(cmdRxLen),
    .cmdBank(cmdBank), .cmdDone(cmdDone), .cmdRxData(cmdRxData),
    .errClr(errClr), .busy(busy), .done(done), .errCode(errCode)
  );

  int nChecks = 0, nFail = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // millisecond tick: one pulse every 8 cycles
  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 8;
    msTick <= (tickDiv == 0);
  end

  // flash model and frame log
  int  wipLeft = 0, postBusy = 0, welBitBank = -1;
  bit  welWorks = 1, welLatch = 0;
  int  pend = 0;
  logic [7:0] respData = '0;
  int  nRdsr, nWren, nErase, nRdsrAfterWren, nClr, nDone, lastErr;
  int  eraseAddr, eraseTx, expBank;
  bit  clrLate, badFrame, bankBad, noTick, sawTick, lastWasRdsr, codeStray, wrenSeen;

  task automatic clearLog();
    nRdsr = 0; nWren = 0; nErase = 0; nRdsrAfterWren = 0; nClr = 0; nDone = 0;
    lastErr = -1; eraseAddr = -1; eraseTx = -1; clrLate = 0; badFrame = 0;
    bankBad = 0; noTick = 0; sawTick = 1; lastWasRdsr = 0; codeStray = 0;
    wrenSeen = 0; welLatch = 0;
  endtask

  always @(negedge clk) begin
    cmdDone <= 1'b0;
    if (msTick) sawTick = 1;
    if (errClr) nClr++;
    if (done) begin nDone++; lastErr = errCode; end
    if (!done && errCode != 2'b00) codeStray = 1;
    if (cmdReq) begin
      if (nClr == 0) clrLate = 1;
      if (cmdBank != expBank[1:0]) bankBad = 1;
      pend = 3;
      respData = '0;
      if (cmdOpcode == 8'h05) begin
        if (cmdTxLen != 3'd1 || cmdRxLen != 2'd1) badFrame = 1;
        if (lastWasRdsr && !sawTick) noTick = 1;
        nRdsr++;
        if (wrenSeen) nRdsrAfterWren++;
        if (wipLeft > 0) begin respData[0] = 1'b1; wipLeft--; end
        if (welLatch)
          respData[4 + ((welBitBank < 0) ? int'(cmdBank) : welBitBank)] = 1'b1;
        lastWasRdsr = 1;
      end else if (cmdOpcode == 8'h06) begin
        if (cmdTxLen != 3'd1 || cmdRxLen != 2'd0) badFrame = 1;
        nWren++; wrenSeen = 1;
        if (welWorks) welLatch = 1;
        lastWasRdsr = 0;
      end else if (cmdOpcode == 8'hD8) begin
        if (cmdRxLen != 2'd0) badFrame = 1;
        nErase++; eraseAddr = int'(cmdAddr); eraseTx = int'(cmdTxLen);
        welLatch = 0; wipLeft = postBusy;
        lastWasRdsr = 0;
      end else badFrame = 1;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        cmdDone   <= 1'b1;
        cmdRxData <= respData;
        sawTick = 0;
      end
    end
  end

  task automatic doRun(input int bank, input int sec, input int sL, input int cL,
                       input int pre, input int wel, input int ers,
                       input int preBusy, input int pBusy, input bit wWorks,
                       input int wBank, input bit inject);
    bit fin = 0;
    clearLog();
    wipLeft = preBusy; postBusy = pBusy; welWorks = wWorks; welBitBank = wBank;
    expBank = bank;
    @(negedge clk);
    bankSel = bank[1:0]; sectorIdx = sec[11:0]; sizeLog2 = sL[4:0]; countLog2 = cL[4:0];
    preLimit = pre[7:0]; welLimit = wel[7:0]; eraseLimit = ers[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int i = 0; i < 4000 && !fin; i++) begin
      @(negedge clk);
      if (inject && i == 10) begin
        sectorIdx = 12'd7; bankSel = 2'd0; start = 1'b1;
      end else start = 1'b0;
      if (done) fin = 1;
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(nDone == 1, "R9 one done pulse", nDone, 1);
    check(busy == 1'b0, "R9 idle after done", busy, 0);
    check(nClr == 1 && !clrLate, "R2 single clear before frames", nClr, 1);
    check(!bankBad, "R10 frame bank", bankBad, 0);
    check(!badFrame, "R3 R5 R6 frame lengths", badFrame, 0);
    check(!noTick, "R3 retry waits for tick", noTick, 0);
    check(!codeStray, "R9 code only with done", codeStray, 0);
  endtask

  task automatic testReset();
    check(!busy && !done && !cmdReq && !errClr && errCode == 2'b00,
          "R1 reset outputs", {busy, done, cmdReq, errClr, errCode}, 0);
  endtask

  task automatic testNormal();
    doRun(1, 5, 20, 4, 5, 3, 10, 2, 3, 1, -1, 0);
    check(lastErr == 0, "R7 success code", lastErr, 0);
    check(nRdsr == 8, "R3 R7 status read count", nRdsr, 8);
    check(nWren == 1, "R5 one write-enable", nWren, 1);
    check(nErase == 1 && eraseAddr == 32'h50000, "R6 erase address", eraseAddr, 32'h50000);
    check(eraseTx == 4, "R6 erase length", eraseTx, 4);
  endtask

  task automatic testLargeGeom();
    doRun(3, 63, 24, 6, 5, 3, 10, 0, 1, 1, -1, 0);
    check(lastErr == 0, "R5 bank 3 latch accepted", lastErr, 0);
    check(eraseAddr == 32'hFC0000, "R6 top sector address", eraseAddr, 32'hFC0000);
  endtask

  task automatic testPreTimeout();
    doRun(0, 2, 20, 4, 3, 3, 10, 1000, 0, 1, -1, 0);
    check(lastErr == 1, "R4 busy code", lastErr, 1);
    check(nRdsr == 3, "R4 read count", nRdsr, 3);
    check(nWren == 0 && nErase == 0, "R4 no enable or erase", nWren + nErase, 0);
  endtask

  task automatic testWelFail();
    doRun(2, 1, 20, 4, 5, 2, 10, 0, 0, 0, -1, 0);
    check(lastErr == 2, "R5 enable failure code", lastErr, 2);
    check(nRdsrAfterWren == 2, "R5 latch reads", nRdsrAfterWren, 2);
    check(nErase == 0, "R5 no erase", nErase, 0);
  endtask

  task automatic testWrongBankBit();
    doRun(2, 1, 20, 4, 5, 2, 10, 0, 0, 1, 0, 0);
    check(lastErr == 2, "R5 other bank latch ignored", lastErr, 2);
    check(nErase == 0, "R5 no erase on wrong bit", nErase, 0);
  endtask

  task automatic testPostTimeout();
    doRun(1, 3, 20, 4, 5, 3, 4, 0, 1000, 1, -1, 0);
    check(lastErr == 1, "R7 erase timeout code", lastErr, 1);
    check(nErase == 1 && nRdsr == 6, "R7 post read count", nRdsr, 6);
  endtask

  task automatic testIgnoreStart();
    doRun(1, 5, 20, 4, 5, 3, 10, 2, 3, 1, -1, 1);
    check(nErase == 1 && eraseAddr == 32'h50000, "R8 busy start ignored", eraseAddr, 32'h50000);
    check(nRdsr == 8 && lastErr == 0, "R8 frame count unchanged", nRdsr, 8);
  endtask

  bit wdFired = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wdFired = 1;
  end

  initial begin
    clearLog();
    expBank = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testNormal();
    testLargeGeom();
    testPreTimeout();
    testWelFail();
    testWrongBankBit();
    testPostTimeout();
    testIgnoreStart();
    check(!wdFired, "R9 watchdog", wdFired, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    wait (wdFired);
    nChecks++; nFail++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule